// File: doc/BRIEF.md
# LCD Common and Segment Scan Sequencer

This block produces the row-scan timing for a dot-matrix liquid crystal panel with 16 common lines and 80 segment lines. It runs from the oscillator clock and steps through the common lines one row period at a time. During each row period it captures the pixel word for the next row and moves it bit by bit through an 80-stage serial path. At the end of the period it transfers the assembled word into the segment latch and moves the one-hot common select to that row. A frame-parity output flips at the start of every frame, so the panel can be driven with alternating polarity.

Two line modes are supported. With one text line, only the first eight commons are scanned, at 1/8 duty, with 400-clock rows. With two text lines, all sixteen are scanned, at 1/16 duty, with 200-clock rows. In both modes a frame lasts 3200 clocks. Four control inputs each reverse one half of the panel: the first eight commons, the last eight commons, the first forty segments or the last forty segments. This lets the panel be mounted in either orientation.

The block asks for pixel data by row. It presents the physical common index on `fetch_row`, and the pixel memory answers on `row_data` within the same row period. Reads of the pixel store happen only at this fixed point of the scan, so they never compete with host traffic to that store.

Top module: `lcd_scan_seq`

## Requirements
- R1: While reset is high and in the cycle after it falls, `com_sel`, `seg_out`, `row_strobe` and `ac_phase` are all zero.
- R2: With `two_line`=1, `row_strobe` pulses once every 200 clocks. The scan visits physical commons 0..15 (bit k of `com_sel` drives common k+1) in ascending order when no reversal is set, and a frame spans 3200 clocks.
- R3: With `two_line`=0, `row_strobe` pulses once every 400 clocks. Only commons 0..7 are selected and `com_sel[15:8]` stays zero, so a frame again spans 3200 clocks.
- R4: `ac_phase` inverts at the strobe that selects the first step of the scan order, and it stays unchanged at every other strobe and between strobes.
- R5: The word on `row_data` while `fetch_row` equals c appears on `seg_out` at the next strobe, together with the selection of common c. With no segment reversal, `seg_out[i]` equals `row_data[i]`.
- R6: When `com_lo_rev`=1, the first eight scan steps select commons 7,6,...,0 instead of 0..7.
- R7: When `com_hi_rev`=1, scan steps 8..15 select commons 15,14,...,8 instead of 8..15.
- R8: When `seg_lo_rev`=1, `seg_out[i]` equals `row_data[39-i]` for i in 0..39.
- R9: When `seg_hi_rev`=1, `seg_out[40+j]` equals `row_data[79-j]` for j in 0..39.
- R10: `com_sel` has at most one bit set. `com_sel` and `seg_out` change only in the cycle in which `row_strobe` is high.
- R11: If `two_line` drops to 0 while the next scan step is 8 or higher, the following strobe restarts at scan step 0, inverts `ac_phase`, and ends a 400-clock row.
- R12: All 80 serial shifts of a row are finished before that row's latch strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| two_line | input | 1 | 1 selects 16-common 1/16 duty, 0 selects 8-common 1/8 duty |
| com_lo_rev | input | 1 | Reverse scan order of commons 0..7 |
| com_hi_rev | input | 1 | Reverse scan order of commons 8..15 |
| seg_lo_rev | input | 1 | Reverse bit order of segments 0..39 |
| seg_hi_rev | input | 1 | Reverse bit order of segments 40..79 |
| row_data | input | 80 | Pixel word for the common named by fetch_row |
| fetch_row | output | 4 | Physical common whose pixel word is requested |
| com_sel | output | 16 | One-hot common select |
| seg_out | output | 80 | Latched segment bits |
| row_strobe | output | 1 | One-cycle pulse in the cycle a new row is latched |
| ac_phase | output | 1 | Frame parity for alternating drive |

## Verification
The hardest case to reach is a line-mode change in the middle of a frame. It has to land when the prepared scan step already lies beyond the eighth common, and before that row's capture edge. The bench runs two-line mode until the strobe that selects scan step 10. In the following cycle it clears `two_line`. It then expects the next strobe to come 400 clocks later, select common 0 with its pixel word, and flip the frame parity. The reversal cases are each run over a full frame, with pixel words that differ in every half. This ensures that a swapped or mirrored half would show up as a mismatch.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  // Sizes of the panel this sequencer is built for.
  localparam int unsigned DEF_NCOM     = 16;
  localparam int unsigned DEF_NSEG     = 80;
  localparam int unsigned DEF_ROW_CLKS = 200;

  // Scan-step to physical common mapping with per-half reversal.
  function automatic int unsigned step_to_com(input int unsigned step,
                                              input int unsigned half,
                                              input logic lo_rev,
                                              input logic hi_rev);
    if (step < half)
      return lo_rev ? (half - 1 - step) : step;
    else
      return hi_rev ? (3 * half - 1 - step) : step;
  endfunction
endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NCOM     = DEF_NCOM,
  parameter int unsigned NSEG     = DEF_NSEG,
  parameter int unsigned ROW_CLKS = DEF_ROW_CLKS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    two_line,
  input  logic                    com_lo_rev,
  input  logic                    com_hi_rev,
  output logic                    cap_en,
  output logic                    shift_en,
  output logic                    strobe,
  output logic                    first_step,
  output logic [$clog2(NCOM)-1:0] phys_com
);
  localparam int unsigned HALF   = NCOM / 2;
  localparam int unsigned STEP_W = $clog2(NCOM);
  localparam int unsigned TICK_W = $clog2(2 * ROW_CLKS);

  logic [TICK_W-1:0] tick;
  logic [STEP_W-1:0] nxt;
  logic [STEP_W-1:0] eff;
  logic [TICK_W-1:0] row_last;
  logic [STEP_W-1:0] last_step;

  always_comb begin
    row_last  = two_line ? TICK_W'(ROW_CLKS - 1) : TICK_W'(2 * ROW_CLKS - 1);
    last_step = two_line ? STEP_W'(NCOM - 1) : STEP_W'(HALF - 1);
    // A step past the active range (after a mode change) restarts the scan.
    eff       = (nxt > last_step) ? '0 : nxt;
    phys_com  = STEP_W'(step_to_com(32'(eff), HALF, com_lo_rev, com_hi_rev));
    strobe    = (tick >= row_last);
    cap_en    = (tick == '0);
    shift_en  = (tick != '0) && (32'(tick) <= NSEG);
    first_step = (eff == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick <= '0;
      nxt  <= '0;
    end else if (strobe) begin
      tick <= '0;
      nxt  <= (eff == last_step) ? '0 : eff + 1'b1;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(tick) < 2 * ROW_CLKS) else $error("tick out of range"); // R2
  AST_ONE_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
    (!two_line && strobe) |-> (32'(phys_com) < HALF)) else $error("upper common in one-line mode"); // R3
endmodule

// File: rtl/lcd_seg_shifter.sv
module lcd_seg_shifter
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NSEG = DEF_NSEG
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_en,
  input  logic            shift_en,
  input  logic            strobe,
  input  logic            seg_lo_rev,
  input  logic            seg_hi_rev,
  input  logic [NSEG-1:0] row_data,
  output logic [NSEG-1:0] seg_out
);
  localparam int unsigned HALF  = NSEG / 2;
  localparam int unsigned CNT_W = $clog2(NSEG + 1);

  logic [NSEG-1:0]  mapped;
  logic [NSEG-1:0]  cap_q;
  logic [NSEG-1:0]  shreg;
  logic [CNT_W-1:0] scnt;

  for (genvar i = 0; i < NSEG; i++) begin : g_map
    if (i < HALF) begin : g_lo
      assign mapped[i] = seg_lo_rev ? row_data[HALF-1-i] : row_data[i];
    end else begin : g_hi
      assign mapped[i] = seg_hi_rev ? row_data[NSEG-1-(i-HALF)] : row_data[i];
    end
  end

  // Parallel capture, then one bit per clock into the serial path.
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= '0;
      shreg <= '0;
      scnt  <= '0;
    end else if (cap_en) begin
      cap_q <= mapped;
      scnt  <= '0;
    end else if (shift_en) begin
      shreg <= {cap_q[0], shreg[NSEG-1:1]};
      cap_q <= {1'b0, cap_q[NSEG-1:1]};
      scnt  <= scnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         seg_out <= '0;
    else if (strobe) seg_out <= shreg;
  end

  AST_SHIFT_DONE: assert property (@(posedge clk) disable iff (rst)
    (strobe && !cap_en) |-> (32'(scnt) == NSEG)) else $error("latch before shift done"); // R12
  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(seg_out)) else $error("segments moved between strobes"); // R10
endmodule

// File: rtl/lcd_com_driver.sv
module lcd_com_driver
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NCOM = DEF_NCOM
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    strobe,
  input  logic                    first_step,
  input  logic [$clog2(NCOM)-1:0] phys_com,
  output logic [NCOM-1:0]         com_sel,
  output logic                    row_strobe,
  output logic                    ac_phase
);
  always_ff @(posedge clk) begin
    if (rst) begin
      com_sel    <= '0;
      row_strobe <= 1'b0;
      ac_phase   <= 1'b0;
    end else begin
      row_strobe <= strobe;
      if (strobe) begin
        com_sel  <= NCOM'(1) << phys_com;
        ac_phase <= ac_phase ^ first_step;
      end
    end
  end

  AST_COM_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(com_sel)) else $error("multiple commons"); // R10
  AST_COM_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(com_sel)) else $error("common moved between strobes"); // R10
  AST_AC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(strobe && first_step) |=> $stable(ac_phase)) else $error("parity flipped mid-frame"); // R4
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NCOM     = DEF_NCOM,
  parameter int unsigned NSEG     = DEF_NSEG,
  parameter int unsigned ROW_CLKS = DEF_ROW_CLKS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    two_line,
  input  logic                    com_lo_rev,
  input  logic                    com_hi_rev,
  input  logic                    seg_lo_rev,
  input  logic                    seg_hi_rev,
  input  logic [NSEG-1:0]         row_data,
  output logic [$clog2(NCOM)-1:0] fetch_row,
  output logic [NCOM-1:0]         com_sel,
  output logic [NSEG-1:0]         seg_out,
  output logic                    row_strobe,
  output logic                    ac_phase
);
  logic cap_en, shift_en, strobe, first_step;
  logic [$clog2(NCOM)-1:0] phys_com;

  lcd_scan_timer #(.NCOM(NCOM), .NSEG(NSEG), .ROW_CLKS(ROW_CLKS)) u_timer (
    .clk(clk), .rst(rst), .two_line(two_line),
    .com_lo_rev(com_lo_rev), .com_hi_rev(com_hi_rev),
    .cap_en(cap_en), .shift_en(shift_en), .strobe(strobe),
    .first_step(first_step), .phys_com(phys_com)
  );

  lcd_seg_shifter #(.NSEG(NSEG)) u_seg (
    .clk(clk), .rst(rst), .cap_en(cap_en), .shift_en(shift_en),
    .strobe(strobe), .seg_lo_rev(seg_lo_rev), .seg_hi_rev(seg_hi_rev),
    .row_data(row_data), .seg_out(seg_out)
  );

  lcd_com_driver #(.NCOM(NCOM)) u_com (
    .clk(clk), .rst(rst), .strobe(strobe), .first_step(first_step),
    .phys_com(phys_com), .com_sel(com_sel), .row_strobe(row_strobe),
    .ac_phase(ac_phase)
  );

  assign fetch_row = phys_com;

  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
    row_strobe |=> !row_strobe) else $error("back-to-back strobes"); // R2
endmodule

// File: tb/lcd_scan_seq_bench.sv
module lcd_scan_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        two_line = 1'b1;
  logic        com_lo_rev = 1'b0, com_hi_rev = 1'b0;
  logic        seg_lo_rev = 1'b0, seg_hi_rev = 1'b0;
  logic [79:0] row_data;
  logic [3:0]  fetch_row;
  logic [15:0] com_sel;
  logic [79:0] seg_out;
  logic        row_strobe, ac_phase;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  lcd_scan_seq u_lcd_scan_seq (
    .clk(clk), .rst(rst), .two_line(two_line),
    .com_lo_rev(com_lo_rev), .com_hi_rev(com_hi_rev),
    .seg_lo_rev(seg_lo_rev), .seg_hi_rev(seg_hi_rev),
    .row_data(row_data), .fetch_row(fetch_row), .com_sel(com_sel),
    .seg_out(seg_out), .row_strobe(row_strobe), .ac_phase(ac_phase)
  );

  function automatic logic [79:0] pat(input logic [3:0] r);
    return {16'h0F1E ^ {12'h0, r}, 16'h2D3C + {12'h0, r}, 16'h4B5A ^ {r, r, r, r},
            16'h6978 - {12'h0, r}, 16'h8796 ^ {r, 12'h0}};
  endfunction

  assign row_data = pat(fetch_row);

  function automatic logic [79:0] exp_seg(input logic [3:0] r, input logic sl, input logic sh);
    logic [79:0] b = pat(r);
    logic [79:0] o;
    for (int i = 0; i < 80; i++) begin
      if (i < 40) o[i] = sl ? b[39-i] : b[i];
      else        o[i] = sh ? b[119-i] : b[i];
    end
    return o;
  endfunction

  function automatic int exp_com(input int k, input logic cl, input logic ch);
    if (k < 8) return cl ? 7 - k : k;
    return ch ? 23 - k : k;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_strobe(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!row_strobe);
  endtask

  task automatic t_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    chk(com_sel == 0, "R1 com_sel in reset", 80'(com_sel), 0);
    chk(seg_out == 0, "R1 seg_out in reset", seg_out, 0);
    chk(row_strobe == 0 && ac_phase == 0, "R1 strobe/ac in reset", {row_strobe, ac_phase}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(com_sel == 0 && seg_out == 0 && !row_strobe && !ac_phase, "R1 first cycle after reset",
        {com_sel, row_strobe, ac_phase}, 0);
  endtask

  // Runs one configuration from reset over a whole frame plus one row.
  task automatic t_scan(input logic tl, input logic cl, input logic ch,
                        input logic sl, input logic sh, input string req);
    int n = tl ? 16 : 8;
    int per = tl ? 200 : 400;
    int cyc, frame_sum;
    logic exp_ac = 1'b0;
    two_line = tl; com_lo_rev = cl; com_hi_rev = ch; seg_lo_rev = sl; seg_hi_rev = sh;
    do_reset();
    frame_sum = 0;
    for (int k = 0; k <= n; k++) begin
      int step = k % n;
      int c = exp_com(step, cl, ch);
      wait_strobe(cyc);
      if (k > 0) begin
        chk(cyc == per, tl ? "R2 row period" : "R3 row period", 80'(cyc), 80'(per));
        frame_sum += cyc;
      end
      if (step == 0) exp_ac = ~exp_ac;
      chk(com_sel == 16'(1 << c), {req, " common"}, 80'(com_sel), 80'(16'(1 << c)));
      chk(seg_out == exp_seg(4'(c), sl, sh), {req, " R5 segments"}, seg_out, exp_seg(4'(c), sl, sh));
      chk(ac_phase == exp_ac, "R4 ac_phase", 80'(ac_phase), 80'(exp_ac));
      if (!tl) chk(com_sel[15:8] == 0, "R3 upper commons idle", 80'(com_sel), 0);
    end
    chk(frame_sum == 3200, tl ? "R2 frame length" : "R3 frame length", 80'(frame_sum), 80'(3200));
    // R10: outputs held mid-row
    begin
      logic [15:0] c0 = com_sel;
      logic [79:0] s0 = seg_out;
      repeat (50) @(negedge clk);
      chk(com_sel == c0 && seg_out == s0, "R10 hold between strobes", seg_out, s0);
    end
  endtask

  task automatic t_mode_switch();
    int cyc;
    two_line = 1'b1; com_lo_rev = 0; com_hi_rev = 0; seg_lo_rev = 0; seg_hi_rev = 0;
    do_reset();
    for (int k = 0; k <= 10; k++) wait_strobe(cyc);
    chk(com_sel == 16'(1 << 10), "R11 precondition common 11", 80'(com_sel), 80'(16'(1 << 10)));
    chk(ac_phase == 1'b1, "R11 precondition ac", 80'(ac_phase), 80'(1));
    two_line = 1'b0;
    wait_strobe(cyc);
    chk(cyc == 400, "R11 row period after switch", 80'(cyc), 80'(400));
    chk(com_sel == 16'h0001, "R11 restart at step 0", 80'(com_sel), 80'(16'h0001));
    chk(seg_out == pat(4'd0), "R11 data of common 0", seg_out, pat(4'd0));
    chk(ac_phase == 1'b0, "R11 ac flips on restart", 80'(ac_phase), 80'(0));
    wait_strobe(cyc);
    chk(com_sel == 16'h0002 && cyc == 400, "R11 continues one-line", {com_sel, 32'(cyc)}, {16'h0002, 32'd400});
  endtask

  initial begin
    t_reset();
    t_scan(1, 0, 0, 0, 0, "R2 two-line normal");
    t_scan(0, 0, 0, 0, 0, "R3 one-line normal");
    t_scan(1, 1, 0, 1, 0, "R6 R8 low halves reversed");
    t_scan(1, 0, 1, 0, 1, "R7 R9 high halves reversed");
    t_scan(0, 1, 1, 1, 1, "R6 R8 R9 one-line all reversed");
    t_mode_switch();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule